// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block makes the 16x oversampling tick that a UART serial engine uses. The system clock first passes through a power-of-two pre-divider. The divided enable then steps an 8-bit reload down-counter. Each time the counter underflows it produces one tick, and sixteen ticks make one bit period. A 4-bit fine-adjust value adds up to fifteen extra divided-clock cycles to every group of sixteen ticks. This gives a bit period of `16*(reload+1)+fine` divided cycles, so the baud rate can be tuned in steps finer than one reload count.

A phase accumulator decides which slots are stretched. It adds the fine value once per slot, and a slot gains one cycle when that addition carries. This spreads the delays evenly across the group instead of bunching them together. A single enable input freezes the block: while it is low, all counting state is cleared.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tick_o` and `bit_o` are 0 after that edge.
- R2: While `en_i` is low, `tick_o` and `bit_o` stay 0, and the divider, counter, slot index and accumulator are held at 0.
- R3: After `en_i` rises, the first tick appears after one divided-clock period: 2^`div_sel_i` system cycles. Slot 0 is never stretched.
- R4: With `fine_i` = 0, consecutive ticks are `(reload_i+1)` divided cycles apart.
- R5: `div_sel_i` codes 0, 1, 2 and 3 divide the system clock by 1, 2, 4 and 8. Every interval scales by that factor.
- R6: Each group of 16 ticks lasts `16*(reload_i+1)+fine_i` divided cycles.
- R7: The accumulator starts at 0 and adds `fine_i` in each slot. A slot is one divided cycle longer exactly when that 4-bit addition carries. So `fine_i`=1 stretches only slot 15, and `fine_i`=8 stretches the odd slots.
- R8: `bit_o` pulses for one cycle together with every 16th tick (slot 15) and never without `tick_o`.
- R9: A new `reload_i` value is used from the next underflow on. The interval already in progress keeps the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Block enable; low clears all counting state |
| div_sel_i | input | 2 | Pre-divider code, divide by 2^code |
| reload_i | input | 8 | Down-counter reload value |
| fine_i | input | 4 | Number of stretched slots per 16-tick group |
| tick_o | output | 1 | One-cycle pulse per counter underflow |
| bit_o | output | 1 | One-cycle pulse on the last tick of each group |

## Verification
A vector table covers every pre-divider code, reload 0, reload 255, and fine values 0, 15 and several in between. For each, the bench measures whole group lengths, so a design that drops or duplicates a delay, or that mis-scales the divider, ends up off by a visible count of cycles. Directed tests then time each slot one at a time for fine values 1 and 8, which catches delays that are bunched or in the wrong slot even when the group total is right. They also check that a reload change mid-interval only alters the following interval; a design that reloads immediately shortens the current one. Further tests cover restart timing after enable for two divider codes, silence while disabled, and output state during reset.

// File: rtl/bt_pkg.sv
// Package: shared helpers for the fractional baud tick generator.
// Assumes divider codes are small enough that 2**code fits in an int.
package bt_pkg;
    // Terminal value of the pre-divider count for a given code.
    function automatic int unsigned pre_limit(input int unsigned code);
        return (32'd1 << code) - 32'd1;
    endfunction
endpackage

// File: rtl/bt_prescaler.sv
// Module: power-of-two pre-divider. Emits a one-cycle enable every
// 2**div_sel system cycles while en is high; cleared while en is low.
// Assumes div_sel only changes while the block is disabled or idle.
module bt_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_sel,
    output logic             ce_o
);
    import bt_pkg::*;
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] pre_cnt;
    logic [CNT_W-1:0] lim;

    // Terminal count for the selected ratio.
    always_comb lim = CNT_W'(pre_limit(int'(div_sel)));

    // Divided enable fires at the terminal count.
    always_comb ce_o = en && (pre_cnt == lim);

    // Count system cycles, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  pre_cnt <= '0;
        else if (ce_o)      pre_cnt <= '0;
        else                pre_cnt <= pre_cnt + 1'b1;
    end

    // R5: with a non-unit ratio held steady, enables are never back to back.
    assert_no_adjacent_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o && div_sel != '0) |=> (!ce_o || div_sel != $past(div_sel)));
endmodule

// File: rtl/bt_spreader.sv
// Module: slot index and phase accumulator. Flags the current slot for a
// one-cycle stretch when acc + fine carries; advances on each underflow.
// Assumes fine is held constant across a group for exact delay counts.
module bt_spreader #(
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [FINE_W-1:0] fine,
    input  logic              uf,
    output logic              dly_o,
    output logic              last_o
);
    logic [FINE_W-1:0] acc;
    logic [FINE_W-1:0] slot;
    logic [FINE_W:0]   sum;

    // Accumulator step and its carry decide the stretch.
    always_comb begin
        sum    = {1'b0, acc} + {1'b0, fine};
        dly_o  = sum[FINE_W];
        last_o = &slot;
    end

    // Advance accumulator and slot once per underflow.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            acc  <= '0;
            slot <= '0;
        end else if (uf) begin
            acc  <= sum[FINE_W-1:0];
            slot <= slot + 1'b1;
        end
    end

    // R7: the first slot of a group always starts from a zero phase.
    assert_slot0_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == '0 && $stable(fine)) |-> (acc == '0 || !$stable(fine) || fine != $past(fine)) || 1'b1 == (acc == '0 || slot != '0));
    // R7: slot 0 is never stretched.
    assert_slot0_unstretched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slot == '0 && acc == '0) |-> !dly_o);
endmodule

// File: rtl/bt_reload_counter.sv
// Module: reload down-counter with optional one-cycle stall at underflow.
// Steps on each divided enable; at zero either inserts the stall requested
// by the spreader or reloads and signals an underflow.
// Assumes ce is already gated by the block enable.
module bt_reload_counter #(
    parameter int RLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ce,
    input  logic [RLD_W-1:0] reload,
    input  logic             dly,
    output logic             uf_o
);
    logic [RLD_W-1:0] cnt;
    logic             stall;
    logic             at_zero;

    // Underflow unless a stall is still owed for this slot.
    always_comb begin
        at_zero = (cnt == '0);
        uf_o    = ce && at_zero && !(dly && !stall);
    end

    // Count down, stall once if asked, reload on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            stall <= 1'b0;
        end else if (ce) begin
            if (!at_zero)           cnt   <= cnt - 1'b1;
            else if (dly && !stall) stall <= 1'b1;
            else begin
                stall <= 1'b0;
                cnt   <= reload;
            end
        end
    end

    // R7: the stall cycle is only ever spent with the counter at zero.
    assert_stall_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> cnt == '0);
    // R9: after an underflow the counter holds the reload sampled at it.
    assert_reload_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uf_o && en) |-> cnt == $past(reload));
endmodule

// File: rtl/baud_tick_gen.sv
// Module: fractional baud tick generator top. Pre-divides the clock,
// runs the reload counter and spreads fine-adjust stalls over each
// 16-slot group; registers the tick and the group strobe.
// Assumes configuration inputs are quasi-static relative to a group.
module baud_tick_gen #(
    parameter int DIV_W  = 2,
    parameter int RLD_W  = 8,
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DIV_W-1:0]  div_sel_i,
    input  logic [RLD_W-1:0]  reload_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic              tick_o,
    output logic              bit_o
);
    logic ce;
    logic uf;
    logic dly;
    logic last;

    bt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en_i), .div_sel(div_sel_i), .ce_o(ce)
    );

    bt_spreader #(.FINE_W(FINE_W)) u_spr (
        .clk(clk), .rst_n(rst_n), .en(en_i), .fine(fine_i), .uf(uf),
        .dly_o(dly), .last_o(last)
    );

    bt_reload_counter #(.RLD_W(RLD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en_i), .ce(ce), .reload(reload_i),
        .dly(dly), .uf_o(uf)
    );

    // Register the tick and the end-of-group strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            tick_o <= 1'b0;
            bit_o  <= 1'b0;
        end else begin
            tick_o <= uf;
            bit_o  <= uf && last;
        end
    end

    // R8: the group strobe never appears without a tick.
    assert_bit_with_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o |-> tick_o);
    // R2: a disabled block emits nothing on the next cycle.
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!tick_o && !bit_o));
    // R1: outputs are cleared by reset.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!tick_o && !bit_o));
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] dsel = '0;
    logic [7:0] rld = '0;
    logic [3:0] fin = '0;
    logic       tick, bitp;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .div_sel_i(dsel),
        .reload_i(rld), .fine_i(fin), .tick_o(tick), .bit_o(bitp)
    );

    // {div_sel, reload, fine, expected group length in system cycles}
    localparam int NV = 8;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 8'd0,   4'd0,  16'd16},
        {2'd0, 8'd0,   4'd15, 16'd31},
        {2'd0, 8'd3,   4'd8,  16'd72},
        {2'd1, 8'd5,   4'd4,  16'd200},
        {2'd2, 8'd9,   4'd1,  16'd644},
        {2'd3, 8'd2,   4'd15, 16'd504},
        {2'd0, 8'd255, 4'd7,  16'd4103},
        {2'd1, 8'd17,  4'd12, 16'd600}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Cycles from now to the next tick, sampled on falling edges.
    task automatic next_tick(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick);
    endtask

    task automatic next_bit(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!bitp);
    endtask

    task automatic restart(input logic [1:0] d, input logic [7:0] r, input logic [3:0] f);
        @(negedge clk);
        en = 1'b0; dsel = d; rld = r; fin = f;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n, ticks;
        // R1: reset with enable high keeps outputs low
        en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 tick in reset", int'(tick), 0);
        check("R1 bit in reset", int'(bitp), 0);
        rst_n = 1'b1;
        en = 1'b0;

        // R2: disabled block stays silent
        ticks = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tick || bitp) ticks++;
        end
        check("R2 pulses while disabled", ticks, 0);

        // R5 R6: table of group lengths
        for (int v = 0; v < NV; v++) begin
            restart(VEC[v][29:28], VEC[v][27:20], VEC[v][19:16]);
            next_bit(n);
            ticks = 0;
            n = 0;
            do begin
                @(negedge clk); n++;
                if (tick) ticks++;
            end while (!bitp);
            check("R6 group length", n, int'(VEC[v][15:0]));
            check("R8 ticks per group", ticks, 16);
        end

        // R3: first tick after enable, divide by 1 and by 4
        restart(2'd0, 8'd5, 4'd3);
        next_tick(n);
        check("R3 first tick div1", n, 1);
        restart(2'd2, 8'd5, 4'd3);
        next_tick(n);
        check("R3 first tick div4", n, 4);

        // R4 R7: fine=1 stretches only slot 15
        restart(2'd0, 8'd3, 4'd1);
        next_bit(n);
        for (int s = 0; s < 16; s++) begin
            next_tick(n);
            check($sformatf("R7 fine1 slot%0d", s), n, (s == 15) ? 5 : 4);
        end
        check("R8 strobe on slot15", int'(bitp), 1);

        // R7: fine=8 stretches odd slots
        restart(2'd0, 8'd1, 4'd8);
        next_bit(n);
        for (int s = 0; s < 16; s++) begin
            next_tick(n);
            check($sformatf("R7 fine8 slot%0d", s), n, 2 + (s % 2));
        end

        // R4: plain interval with fine 0, divide by 2
        restart(2'd1, 8'd6, 4'd0);
        next_tick(n);
        next_tick(n);
        check("R4 R5 interval div2", n, 14);

        // R9: reload change applies from next underflow
        restart(2'd0, 8'd3, 4'd0);
        next_tick(n);
        next_tick(n);
        rld = 8'd7;
        next_tick(n);
        check("R9 current interval keeps old reload", n, 4);
        next_tick(n);
        check("R9 next interval uses new reload", n, 8);

        // R2: disabling mid-run silences outputs
        @(negedge clk);
        en = 1'b0;
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick || bitp) ticks++;
        end
        check("R2 pulses after disable", ticks, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule